// File: doc/BRIEF.md
# Lookup Result Arbitration Unit

This unit turns the outcome of three searches made for one packet into one forwarding decision. The three searches are a route search, a primary filter search and an auxiliary filter search. For each search the unit receives a compact 32-bit hit word and the decoded full result. From these it chooses where the packet goes (a port or a plugin), its queue ID and its 48-bit next-hop field. It raises the action flags drop, send to the control processor, no-MAC, no-route and malformed. It also says whether an extra copy must be made for the auxiliary filter, and gives that copy's destination.

The primary filter and the route search compete on priority. Every route carries the same fixed priority, which is set by a parameter. The primary filter brings its own 8-bit priority in its hit word. A unicast decision that has no valid next-hop MAC is sent to the control processor marked no-MAC, so that address resolution can happen there. That need for resolution also cancels any auxiliary copy.

Both sides use valid/ready. An input set transfers when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only when the output register is empty or is being drained in the same cycle, and all three hit words carry their done bit. A decision stays on the outputs, unchanged, until `out_ready` takes it. A full output register with `out_ready` low therefore holds `in_ready` low.

Top module: `lkup_arbiter`

## Requirements
- R1: The hit word layout is done at bit 31, hit at bit 30, multi-hit at bit 29, priority at bits 28:21, a spare bit at bit 20 and the result word address at bits 19:0. While any of the three done bits is 0, `in_ready` stays low and no decision is produced.
- R2: A decision is presented on `out_valid` in the cycle after its inputs transfer. While `out_valid` is high and `out_ready` is low, all outputs hold steady. Decisions leave in the order their inputs arrived, and none is lost or repeated.
- R3: The route result is 72 bits: port [71:68], queue ID [67:51], next-hop [50:3], multicast-valid [2], IP-valid [1], MAC-valid [0]. A filter result is 76 bits: port [75:72], queue ID [71:55], next-hop [54:7], multicast-valid [6], IP-valid [5], MAC-valid [4], to-control [3], drop [2], sampling [1:0]. The primary result supplies the decision (`out_from_pf`=1) when the primary search hits and either the route search misses or the primary priority exceeds ROUTE_PRIO. When the two priorities are equal, the primary result wins only if PF_WINS_TIE=1. In every other case a route hit supplies the decision.
- R4: The priority bits in the route and auxiliary hit words have no effect on any output.
- R5: If more than one of the three valid bits of the selected result is set, `out_malformed` is 1, and `out_to_cp` is 1 unless drop applies.
- R6: A selected result with multicast-valid 0 and MAC-valid 0, no drop and no to-control bit, and not malformed gives `out_no_mac`=1 and `out_to_cp`=1.
- R7: The drop bit of a selected primary result sets `out_drop` and forces `out_to_cp` to 0. Without drop, its to-control bit sets `out_to_cp`.
- R8: When neither the route search nor the primary search hits, `out_no_route`=1, `out_to_cp`=1, `out_drop`=0, `out_from_pf`=0, and port, queue ID, next-hop and multicast are 0.
- R9: `aux_copy` is 1 when the auxiliary search hits and `out_no_mac` is 0. In that case `aux_port`, `aux_qid`, `aux_nh` and `aux_sample` carry the auxiliary result's fields. Otherwise they are 0.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input set is valid |
| in_ready | output | 1 | Input set can be taken |
| rt_hit_word | input | 32 | Route search hit word |
| rt_result | input | 72 | Route full result |
| pf_hit_word | input | 32 | Primary filter hit word |
| pf_result | input | 76 | Primary filter full result |
| ax_hit_word | input | 32 | Auxiliary filter hit word |
| ax_result | input | 76 | Auxiliary filter full result |
| out_valid | output | 1 | Decision is valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_port | output | 4 | Selected port or plugin |
| out_qid | output | 17 | Selected queue ID |
| out_nh | output | 48 | Selected next-hop or copy vector |
| out_mcast | output | 1 | Selected result is multicast |
| out_drop | output | 1 | Drop the packet |
| out_to_cp | output | 1 | Send to the control processor |
| out_no_mac | output | 1 | Unicast without a next-hop MAC |
| out_no_route | output | 1 | Neither route nor primary hit |
| out_malformed | output | 1 | More than one valid bit set |
| out_from_pf | output | 1 | Primary filter supplied the decision |
| aux_copy | output | 1 | Make an auxiliary copy |
| aux_port | output | 4 | Auxiliary copy port or plugin |
| aux_qid | output | 17 | Auxiliary copy queue ID |
| aux_nh | output | 48 | Auxiliary copy next-hop |
| aux_sample | output | 2 | Auxiliary sampling bits |

## Verification
The bench builds the unit with ROUTE_PRIO=100 and PF_WINS_TIE=1. With these values, primary priorities above, below and equal to the route priority can all be set up directly from 8-bit hit words. The equal-priority case exercises the variant in which the filter wins ties. The default build keeps the other variant in place for elaboration. A long run of random results under random `out_ready` stalls puts the hold-while-stalled and ordering rules under pressure, while malformed, no-MAC, drop and no-route combinations also come up in that run.

// File: rtl/lkup_arb_pkg.sv
package lkup_arb_pkg;
  localparam int PORT_W = 4;
  localparam int QID_W  = 17;
  localparam int NH_W   = 48;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 20;
  localparam int SAMP_W = 2;

  localparam int HIT_W    = 3 + PRIO_W + 1 + ADDR_W;
  localparam int DONE_POS = HIT_W - 1;
  localparam int HIT_POS  = HIT_W - 2;
  localparam int MHIT_POS = HIT_W - 3;
  localparam int PRIO_LSB = HIT_W - 3 - PRIO_W;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [QID_W-1:0]  qid;
    logic [NH_W-1:0]   nh;
    logic              mcast;
    logic              ip_v;
    logic              mac_v;
  } route_bus_t;

  // Filter bus layout; also the normalized form of any result
  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [QID_W-1:0]  qid;
    logic [NH_W-1:0]   nh;
    logic              mcast;
    logic              ip_v;
    logic              mac_v;
    logic              to_cp;
    logic              drop;
    logic [SAMP_W-1:0] sample;
  } fwd_t;

  localparam int RT_RES_W = $bits(route_bus_t);
  localparam int PF_RES_W = $bits(fwd_t);

  typedef struct packed {
    logic              done;
    logic              hit;
    logic [PRIO_W-1:0] prio;
  } hit_info_t;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [QID_W-1:0]  qid;
    logic [NH_W-1:0]   nh;
    logic              mcast;
    logic              drop;
    logic              to_cp;
    logic              no_mac;
    logic              no_route;
    logic              malformed;
    logic              from_pf;
    logic              aux_copy;
    logic [PORT_W-1:0] aux_port;
    logic [QID_W-1:0]  aux_qid;
    logic [NH_W-1:0]   aux_nh;
    logic [SAMP_W-1:0] aux_sample;
  } decision_t;

  localparam int DEC_W = $bits(decision_t);
endpackage

// File: rtl/lkup_hit_decode.sv
module lkup_hit_decode
  import lkup_arb_pkg::*;
(
  input  logic [HIT_W-1:0] word,
  output hit_info_t        info
);
  logic unused_hit_bits;

  assign info.done = word[DONE_POS];
  assign info.hit  = word[HIT_POS];
  assign info.prio = word[PRIO_LSB +: PRIO_W];
  // multi-hit, spare and address are carried but not acted on here
  assign unused_hit_bits = ^{word[MHIT_POS], word[PRIO_LSB-1:0]};
endmodule

// File: rtl/lkup_res_unpack.sv
module lkup_res_unpack
  import lkup_arb_pkg::*;
#(
  parameter bit IS_FILTER = 1'b1,
  parameter int BUS_W     = IS_FILTER ? PF_RES_W : RT_RES_W
) (
  input  logic [BUS_W-1:0] bus,
  output fwd_t             res
);
  generate
    if (IS_FILTER) begin : g_filter
      assign res = fwd_t'(bus);
    end else begin : g_route
      route_bus_t r;
      assign r = route_bus_t'(bus);
      always_comb begin
        res        = '0;
        res.port   = r.port;
        res.qid    = r.qid;
        res.nh     = r.nh;
        res.mcast  = r.mcast;
        res.ip_v   = r.ip_v;
        res.mac_v  = r.mac_v;
      end
    end
  endgenerate
endmodule

// File: rtl/lkup_decide.sv
module lkup_decide
  import lkup_arb_pkg::*;
#(
  parameter logic [PRIO_W-1:0] ROUTE_PRIO  = 8'd64,
  parameter bit                PF_WINS_TIE = 1'b0
) (
  input  logic              rt_hit,
  input  logic              pf_hit,
  input  logic [PRIO_W-1:0] pf_prio,
  input  logic              ax_hit,
  input  fwd_t              rt_res,
  input  fwd_t              pf_res,
  input  fwd_t              ax_res,
  output decision_t         dec
);
  logic pf_beats;
  logic use_pf;
  logic fwd_hit;
  fwd_t sel;
  logic multi_v;
  logic drop_eff;
  logic need_arp;
  logic unused_dec;

  generate
    if (PF_WINS_TIE) begin : g_tie_pf
      assign pf_beats = (pf_prio >= ROUTE_PRIO);
    end else begin : g_tie_rt
      assign pf_beats = (pf_prio > ROUTE_PRIO);
    end
  endgenerate

  assign use_pf  = pf_hit && (!rt_hit || pf_beats);
  assign fwd_hit = use_pf || rt_hit;

  always_comb begin
    if (use_pf)      sel = pf_res;
    else if (rt_hit) sel = rt_res;
    else             sel = '0;
  end

  assign multi_v  = (sel.mcast & sel.ip_v) | (sel.mcast & sel.mac_v) |
                    (sel.ip_v & sel.mac_v);
  assign drop_eff = fwd_hit && sel.drop;
  assign need_arp = fwd_hit && !sel.drop && !sel.to_cp && !multi_v &&
                    !sel.mcast && !sel.mac_v;

  always_comb begin
    dec            = '0;
    dec.port       = sel.port;
    dec.qid        = sel.qid;
    dec.nh         = sel.nh;
    dec.mcast      = sel.mcast;
    dec.from_pf    = use_pf;
    dec.drop       = drop_eff;
    dec.malformed  = fwd_hit && multi_v;
    dec.no_mac     = need_arp;
    dec.no_route   = !fwd_hit;
    dec.to_cp      = !drop_eff &&
                     (sel.to_cp || !fwd_hit || multi_v || need_arp);
    dec.aux_copy   = ax_hit && !need_arp;
    if (dec.aux_copy) begin
      dec.aux_port   = ax_res.port;
      dec.aux_qid    = ax_res.qid;
      dec.aux_nh     = ax_res.nh;
      dec.aux_sample = ax_res.sample;
    end
  end

  // sampling of the forwarding source and aux action/valid bits are not used
  assign unused_dec = ^{sel.sample, ax_res.mcast, ax_res.ip_v, ax_res.mac_v,
                        ax_res.to_cp, ax_res.drop};
endmodule

// File: rtl/lkup_out_stage.sv
module lkup_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lkup_arbiter.sv
module lkup_arbiter
  import lkup_arb_pkg::*;
#(
  parameter logic [PRIO_W-1:0] ROUTE_PRIO  = 8'd64,
  parameter bit                PF_WINS_TIE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [HIT_W-1:0]    rt_hit_word,
  input  logic [RT_RES_W-1:0] rt_result,
  input  logic [HIT_W-1:0]    pf_hit_word,
  input  logic [PF_RES_W-1:0] pf_result,
  input  logic [HIT_W-1:0]    ax_hit_word,
  input  logic [PF_RES_W-1:0] ax_result,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PORT_W-1:0]   out_port,
  output logic [QID_W-1:0]    out_qid,
  output logic [NH_W-1:0]     out_nh,
  output logic                out_mcast,
  output logic                out_drop,
  output logic                out_to_cp,
  output logic                out_no_mac,
  output logic                out_no_route,
  output logic                out_malformed,
  output logic                out_from_pf,
  output logic                aux_copy,
  output logic [PORT_W-1:0]   aux_port,
  output logic [QID_W-1:0]    aux_qid,
  output logic [NH_W-1:0]     aux_nh,
  output logic [SAMP_W-1:0]   aux_sample
);
  localparam int NSRCH = 3;

  logic [HIT_W-1:0] words [NSRCH];
  hit_info_t        infos [NSRCH];
  fwd_t             rt_f, pf_f, ax_f;
  decision_t        dec, dec_q;
  logic [DEC_W-1:0] dec_bits;
  logic             all_done;
  logic             slot_free;
  logic             load;
  logic             unused_prio;

  assign words[0] = rt_hit_word;
  assign words[1] = pf_hit_word;
  assign words[2] = ax_hit_word;

  generate
    for (genvar g = 0; g < NSRCH; g++) begin : g_hit
      lkup_hit_decode u_dec (.word(words[g]), .info(infos[g]));
    end
  endgenerate

  lkup_res_unpack #(.IS_FILTER(1'b0)) u_rt_unp (.bus(rt_result), .res(rt_f));
  lkup_res_unpack #(.IS_FILTER(1'b1)) u_pf_unp (.bus(pf_result), .res(pf_f));
  lkup_res_unpack #(.IS_FILTER(1'b1)) u_ax_unp (.bus(ax_result), .res(ax_f));

  lkup_decide #(
    .ROUTE_PRIO (ROUTE_PRIO),
    .PF_WINS_TIE(PF_WINS_TIE)
  ) u_decide (
    .rt_hit (infos[0].hit),
    .pf_hit (infos[1].hit),
    .pf_prio(infos[1].prio),
    .ax_hit (infos[2].hit),
    .rt_res (rt_f),
    .pf_res (pf_f),
    .ax_res (ax_f),
    .dec    (dec)
  );

  assign all_done  = infos[0].done & infos[1].done & infos[2].done;
  assign slot_free = !out_valid || out_ready;
  assign in_ready  = slot_free && all_done;
  assign load      = in_valid && in_ready;

  lkup_out_stage #(.DW(DEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .din      (dec),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .dout     (dec_bits)
  );

  assign dec_q = decision_t'(dec_bits);

  assign out_port      = dec_q.port;
  assign out_qid       = dec_q.qid;
  assign out_nh        = dec_q.nh;
  assign out_mcast     = dec_q.mcast;
  assign out_drop      = dec_q.drop;
  assign out_to_cp     = dec_q.to_cp;
  assign out_no_mac    = dec_q.no_mac;
  assign out_no_route  = dec_q.no_route;
  assign out_malformed = dec_q.malformed;
  assign out_from_pf   = dec_q.from_pf;
  assign aux_copy      = dec_q.aux_copy;
  assign aux_port      = dec_q.aux_port;
  assign aux_qid       = dec_q.aux_qid;
  assign aux_nh        = dec_q.aux_nh;
  assign aux_sample    = dec_q.aux_sample;

  // route and auxiliary priorities carry no meaning (R4)
  assign unused_prio = ^{infos[0].prio, infos[2].prio};
endmodule

// File: rtl/lkup_arbiter_chk.sv
module lkup_arbiter_chk
  import lkup_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port,
  input logic [QID_W-1:0]  out_qid,
  input logic [NH_W-1:0]   out_nh,
  input logic              out_drop,
  input logic              out_to_cp,
  input logic              out_no_mac,
  input logic              out_no_route,
  input logic              out_malformed,
  input logic              aux_copy
);
  // R1
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_valid) |=> !out_valid);

  // R2
  next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_port, out_qid, out_nh, out_drop, out_to_cp})));

  // R5
  malformed_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_malformed) |-> (out_drop || out_to_cp));

  // R7
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_drop && out_to_cp));

  // R8
  no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_no_route) |-> (out_to_cp && !out_drop));

  // R9
  arp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_no_mac) |-> !aux_copy);
endmodule

bind lkup_arbiter lkup_arbiter_chk u_chk (.*);

// File: tb/tb_lkup_arbiter.sv
`timescale 1ns/1ps
module tb_lkup_arbiter;
  localparam logic [7:0] RP  = 8'd100;
  localparam bit         TIE = 1'b1;
  localparam int         OW  = 148;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] rt_hit_word, pf_hit_word, ax_hit_word;
  logic [71:0] rt_result;
  logic [75:0] pf_result, ax_result;
  logic [3:0]  out_port, aux_port;
  logic [16:0] out_qid, aux_qid;
  logic [47:0] out_nh, aux_nh;
  logic [1:0]  aux_sample;
  logic out_mcast, out_drop, out_to_cp, out_no_mac, out_no_route;
  logic out_malformed, out_from_pf, aux_copy;

  lkup_arbiter #(.ROUTE_PRIO(RP), .PF_WINS_TIE(TIE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rt_hit_word(rt_hit_word), .rt_result(rt_result),
    .pf_hit_word(pf_hit_word), .pf_result(pf_result),
    .ax_hit_word(ax_hit_word), .ax_result(ax_result),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_qid(out_qid), .out_nh(out_nh),
    .out_mcast(out_mcast), .out_drop(out_drop), .out_to_cp(out_to_cp),
    .out_no_mac(out_no_mac), .out_no_route(out_no_route),
    .out_malformed(out_malformed), .out_from_pf(out_from_pf),
    .aux_copy(aux_copy), .aux_port(aux_port), .aux_qid(aux_qid),
    .aux_nh(aux_nh), .aux_sample(aux_sample)
  );

  logic [OW-1:0] got;
  assign got = {out_port, out_qid, out_nh, out_mcast, out_drop, out_to_cp,
                out_no_mac, out_no_route, out_malformed, out_from_pf,
                aux_copy, aux_port, aux_qid, aux_nh, aux_sample};

  logic [OW-1:0] exp_q[$];
  string         tag_q[$];
  int            checks = 0;
  int            fails  = 0;
  bit            rdy_rand = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [31:0] hw(input bit done, input bit hit,
                                     input logic [7:0] prio);
    return {done, hit, 1'b0, prio, 1'b0, 20'h5A5A5};
  endfunction

  function automatic logic [71:0] rres(input logic [3:0] p, input logic [16:0] q,
                                       input logic [47:0] n, input logic [2:0] vb);
    return {p, q, n, vb};
  endfunction

  function automatic logic [75:0] fres(input logic [3:0] p, input logic [16:0] q,
                                       input logic [47:0] n, input logic [2:0] vb,
                                       input bit tocp, input bit drop,
                                       input logic [1:0] s);
    return {p, q, n, vb, tocp, drop, s};
  endfunction

  // Expected decision from the requirements (R3..R9)
  function automatic logic [OW-1:0] model(
      input logic [31:0] rw, input logic [71:0] rr,
      input logic [31:0] pw, input logic [75:0] pr,
      input logic [31:0] aw, input logic [75:0] ar);
    bit rh, ph, ah, use_pf, fwd, mc, ipv, macv, stocp, sdrop;
    bit malf, drop, nomac, noroute, tocp, auxc;
    logic [3:0] port; logic [16:0] qid; logic [47:0] nh;
    rh = rw[30]; ph = pw[30]; ah = aw[30];
    use_pf = ph && (!rh || (TIE ? (pw[28:21] >= RP) : (pw[28:21] > RP)));
    fwd = use_pf || rh;
    if (use_pf) begin
      port = pr[75:72]; qid = pr[71:55]; nh = pr[54:7];
      mc = pr[6]; ipv = pr[5]; macv = pr[4]; stocp = pr[3]; sdrop = pr[2];
    end else if (rh) begin
      port = rr[71:68]; qid = rr[67:51]; nh = rr[50:3];
      mc = rr[2]; ipv = rr[1]; macv = rr[0]; stocp = 0; sdrop = 0;
    end else begin
      port = '0; qid = '0; nh = '0; mc = 0; ipv = 0; macv = 0; stocp = 0; sdrop = 0;
    end
    malf    = fwd && ((int'(mc) + int'(ipv) + int'(macv)) > 1);
    drop    = fwd && sdrop;
    nomac   = fwd && !sdrop && !stocp && !malf && !mc && !macv;
    noroute = !fwd;
    tocp    = !drop && (stocp || noroute || malf || nomac);
    auxc    = ah && !nomac;
    return {port, qid, nh, mc, drop, tocp, nomac, noroute, malf, use_pf, auxc,
            auxc ? ar[75:72] : 4'h0, auxc ? ar[71:55] : 17'h0,
            auxc ? ar[54:7] : 48'h0, auxc ? ar[1:0] : 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [OW-1:0] act,
                     input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] rw, input logic [71:0] rr,
                      input logic [31:0] pw, input logic [75:0] pr,
                      input logic [31:0] aw, input logic [75:0] ar,
                      input string tag);
    @(negedge clk);
    rt_hit_word = rw; rt_result = rr;
    pf_hit_word = pw; pf_result = pr;
    ax_hit_word = aw; ax_result = ar;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(rw, rr, pw, pr, aw, ar));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Monitor: pops the scoreboard at each output transfer (R2 ordering)
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: got unexpected decision %h expected none", got);
        end else begin
          chk(tag_q.pop_front(), got, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  localparam logic [2:0] VM = 3'b001, VI = 3'b010, VC = 3'b100;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    rt_hit_word = '0; pf_hit_word = '0; ax_hit_word = '0;
    rt_result = '0; pf_result = '0; ax_result = '0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk("R10", {147'b0, out_valid}, '0);
    rst_n = 1'b1;

    // R1: primary done bit clear blocks transfer
    @(negedge clk);
    rt_hit_word = hw(1, 1, 0); pf_hit_word = hw(0, 1, 8'd200);
    ax_hit_word = hw(1, 0, 0); in_valid = 1'b1;
    #1;
    chk("R1", {147'b0, in_ready}, '0);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", {147'b0, out_valid}, '0);
    in_valid = 1'b0;

    // R2: decision one cycle after transfer
    send(hw(1, 1, 0), rres(4'd3, 17'h101, 48'h0000_1111_2222, VM),
         hw(1, 0, 0), '0, hw(1, 0, 0), '0, "R3");
    @(negedge clk);
    #1;
    chk("R2", {147'b0, out_valid}, {147'b0, 1'b1});
    in_valid = 1'b0;

    // R3: priority comparison, including tie
    send(hw(1, 1, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 1, 8'd200), fres(4'd5, 17'h55, 48'h5, VM, 0, 0, 0),
         hw(1, 0, 0), '0, "R3");
    send(hw(1, 1, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 1, 8'd50), fres(4'd5, 17'h55, 48'h5, VM, 0, 0, 0),
         hw(1, 0, 0), '0, "R3");
    send(hw(1, 1, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 1, 8'd100), fres(4'd6, 17'h66, 48'h6, VM, 0, 0, 0),
         hw(1, 0, 0), '0, "R3");
    // R4: route and aux priority bits ignored
    send(hw(1, 1, 8'hFF), rres(4'd2, 17'h22, 48'h2, VM),
         hw(1, 1, 8'd150), fres(4'd7, 17'h77, 48'h7, VM, 0, 0, 0),
         hw(1, 1, 8'hFF), fres(4'd9, 17'h99, 48'h9, VC, 0, 0, 2'b01), "R4");
    send(hw(1, 1, 8'hC3), rres(4'd2, 17'h22, 48'h2, VM),
         hw(1, 0, 0), '0,
         hw(1, 1, 8'h3C), fres(4'd9, 17'h99, 48'h9, VC, 0, 0, 2'b11), "R4");
    // R5: two valid bits set
    send(hw(1, 1, 0), rres(4'd4, 17'h44, 48'h4, VI | VM),
         hw(1, 0, 0), '0, hw(1, 0, 0), '0, "R5");
    send(hw(1, 0, 0), '0,
         hw(1, 1, 8'd120), fres(4'd4, 17'h44, 48'h4, VC | VM, 0, 0, 0),
         hw(1, 0, 0), '0, "R5");
    // R6: unicast without MAC
    send(hw(1, 1, 0), rres(4'd8, 17'h88, 48'hC0A8_0001, VI),
         hw(1, 0, 0), '0, hw(1, 0, 0), '0, "R6");
    send(hw(1, 1, 0), rres(4'd8, 17'h88, 48'h0, 3'b000),
         hw(1, 0, 0), '0, hw(1, 0, 0), '0, "R6");
    // R9: no-MAC cancels the auxiliary copy
    send(hw(1, 1, 0), rres(4'd8, 17'h88, 48'h0, VI),
         hw(1, 0, 0), '0,
         hw(1, 1, 0), fres(4'd3, 17'h33, 48'h3, VM, 0, 0, 2'b10), "R9");
    // R7: drop over to-control, then to-control alone
    send(hw(1, 1, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 1, 8'd200), fres(4'd5, 17'h55, 48'h5, 3'b000, 1, 1, 0),
         hw(1, 0, 0), '0, "R7");
    send(hw(1, 1, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 1, 8'd200), fres(4'd5, 17'h55, 48'h5, VM, 1, 0, 0),
         hw(1, 0, 0), '0, "R7");
    // R8: no forwarding hit, with and without aux hit
    send(hw(1, 0, 0), rres(4'd1, 17'h11, 48'h1, VM),
         hw(1, 0, 8'd200), fres(4'd5, 17'h55, 48'h5, VM, 0, 1, 0),
         hw(1, 0, 0), '0, "R8");
    send(hw(1, 0, 0), '0, hw(1, 0, 0), '0,
         hw(1, 1, 0), fres(4'd2, 17'h21, 48'h12, VM, 0, 0, 2'b01), "R8");
    // R9: multicast decision with auxiliary copy
    send(hw(1, 1, 0), rres(4'd0, 17'h1F, 48'h0000_0000_03FF, VC),
         hw(1, 0, 0), '0,
         hw(1, 1, 0), fres(4'd6, 17'h1ABCD, 48'hDEAD_BEEF_0001, VM, 1, 1, 2'b10), "R9");
    idle();

    // R2: random stream under random back-pressure
    rdy_rand = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rw, pw, aw;
      logic [71:0] rr;
      logic [75:0] pr, ar;
      rw = hw(1, 1'($urandom), 8'($urandom));
      pw = hw(1, 1'($urandom), 8'($urandom_range(90, 110)));
      aw = hw(1, 1'($urandom), 8'($urandom));
      rr = {$urandom, $urandom, 8'($urandom)};
      pr = {$urandom, $urandom, 12'($urandom)};
      ar = {$urandom, $urandom, 12'($urandom)};
      send(rw, rr, pw, pr, aw, ar, "R2");
    end
    idle();
    repeat (60) @(negedge clk);
    rdy_rand = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    // R2: every decision drained, none left behind
    chk("R2", OW'(exp_q.size()), '0);
    summary();
    $finish;
  end
endmodule